// File: doc/BRIEF.md
# Pad Wake-Up Detector

This block watches a small group of input pads while the system sleeps and raises one wake request when any armed pad shows its programmed condition. Each pad can be armed on its own and set to respond either to a level (high or low) or to an edge (rising or falling). Pad inputs are asynchronous to the block clock and pass through a two-flop synchronizer before any detection takes place.

Software programs three per-pad configuration registers and one register of pending edge events through a simple write port and a combinational read port. An edge event stays pending until software clears it by writing a one to its bit. A level condition is never stored and drops as soon as the pad leaves the qualifying level. Only the pads whose index is at or below a fixed limit can act as wake sources; the configuration and pending bits of the other pads are tied to zero.

Top module: `pad_wake_detector`

## Requirements
- R1: After reset every register reads 0 and `wake_req` is low.
- R2: Register address 0 holds the arm bits, address 1 the mode bits (0 = level, 1 = edge), address 2 the polarity bits (0 = high level or rising edge, 1 = low level or falling edge) and address 3 the pending edge events; bit i of each belongs to pad i. A write to addresses 0 to 2 replaces the register at the next clock edge, and `cfg_rdata` shows the register chosen by `cfg_raddr` in the same cycle.
- R3: Pads with an index above `MAX_WAKE_PAD` (pads 6 and 7 with defaults) ignore writes, read back 0 at every address and never cause a wake request.
- R4: With a pad armed in level mode and polarity 0, `wake_req` is high while the synchronized pad is high: a change driven between clock edges shows on `wake_req` after the second following rising clock edge, and the request is not held once the pad goes low.
- R5: With a pad armed in level mode and polarity 1, `wake_req` is high while the synchronized pad is low.
- R6: With a pad armed in edge mode and polarity 0, a rising edge of the pad sets its pending bit after the third following rising clock edge, and the bit and `wake_req` stay high after the pad falls again.
- R7: With a pad armed in edge mode and polarity 1, a falling edge sets its pending bit and a rising edge does not.
- R8: Writing address 3 clears exactly the pending bits written as 1; bits written as 0 keep their value, and an edge arriving in the same cycle as its clear leaves the bit set.
- R9: A pad whose arm bit is 0 neither sets a pending bit nor raises a level request.
- R10: `wake_req` is the OR of all armed level conditions and all pending edge bits; clearing one source leaves the request high while another remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | N_PADS | Raw pad levels, asynchronous to `clk` |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 2 | Register write address |
| cfg_wdata | input | N_PADS | Register write data |
| cfg_raddr | input | 2 | Register read address |
| cfg_rdata | output | N_PADS | Contents of the addressed register |
| wake_req | output | 1 | Wake request to the power controller |

## Verification
The assertions assume reset is asserted before the first clock and that at most one register write happens per cycle, which the bench keeps by driving every input only just after a falling clock edge. They take pad inputs as arbitrary bit streams, so the bench moves pads freely, including on pads that are disarmed or not wake-capable, while a behavioural model tracks the synchronizer, the pending bits and the wake request each cycle.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

  localparam int unsigned PWD_MAX_WIDTH = 64;

  typedef enum logic [1:0] {
    REG_ARM     = 2'd0,
    REG_MODE    = 2'd1,
    REG_POLAR   = 2'd2,
    REG_PENDING = 2'd3
  } wake_reg_e;

  // Pads with index at or below max_pad are wake-capable.
  function automatic logic [PWD_MAX_WIDTH-1:0] capable_mask(input int unsigned max_pad);
    logic [PWD_MAX_WIDTH-1:0] m;
    m = '0;
    for (int i = 0; i < PWD_MAX_WIDTH; i++) begin
      if (i <= max_pad) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pwd_sync.sv
module pwd_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/pwd_cfg_regs.sv
module pwd_cfg_regs
  import pwd_pkg::*;
#(
  parameter int unsigned N_PADS = 8,
  parameter logic [N_PADS-1:0] CAP = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        waddr,
  input  logic [N_PADS-1:0] wdata,
  input  logic [1:0]        raddr,
  input  logic [N_PADS-1:0] pending,
  output logic [N_PADS-1:0] arm_q,
  output logic [N_PADS-1:0] mode_q,
  output logic [N_PADS-1:0] polar_q,
  output logic [N_PADS-1:0] clr_mask,
  output logic [N_PADS-1:0] rdata
);

  wake_reg_e wsel, rsel;
  logic [N_PADS-1:0] wdata_cap;
  logic wr_arm, wr_mode, wr_polar, wr_clear;

  assign wsel      = wake_reg_e'(waddr);
  assign rsel      = wake_reg_e'(raddr);
  assign wdata_cap = wdata & CAP;

  assign wr_arm   = we && (wsel == REG_ARM);
  assign wr_mode  = we && (wsel == REG_MODE);
  assign wr_polar = we && (wsel == REG_POLAR);
  assign wr_clear = we && (wsel == REG_PENDING);

  assign clr_mask = wr_clear ? wdata_cap : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q   <= '0;
      mode_q  <= '0;
      polar_q <= '0;
    end else begin
      if (wr_arm)   arm_q   <= wdata_cap;
      if (wr_mode)  mode_q  <= wdata_cap;
      if (wr_polar) polar_q <= wdata_cap;
    end
  end

  always_comb begin
    unique case (rsel)
      REG_ARM:     rdata = arm_q;
      REG_MODE:    rdata = mode_q;
      REG_POLAR:   rdata = polar_q;
      REG_PENDING: rdata = pending;
      default:     rdata = '0;
    endcase
  end

  // R3: configuration of non-capable pads never holds a one.
  p_cfg_capable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((arm_q | mode_q | polar_q) & ~CAP) == '0);

  // R2: a configuration register changes only after a write to it.
  p_arm_only_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_arm |=> $stable(arm_q));

endmodule

// File: rtl/pwd_detect.sv
module pwd_detect #(
  parameter int unsigned N_PADS = 8,
  parameter logic [N_PADS-1:0] CAP = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PADS-1:0] pad_sync,
  input  logic [N_PADS-1:0] arm,
  input  logic [N_PADS-1:0] mode,
  input  logic [N_PADS-1:0] polar,
  input  logic [N_PADS-1:0] clr_mask,
  output logic [N_PADS-1:0] pending,
  output logic [N_PADS-1:0] level_hit,
  output logic              wake_req
);

  // Edge toward the active polarity: rising when pol=0, falling when pol=1.
  function automatic logic [N_PADS-1:0] directed_edge(
    input logic [N_PADS-1:0] cur,
    input logic [N_PADS-1:0] prev,
    input logic [N_PADS-1:0] pol
  );
    return (cur & ~prev & ~pol) | (~cur & prev & pol);
  endfunction

  // Level at the active polarity: high when pol=0, low when pol=1.
  function automatic logic [N_PADS-1:0] active_level(
    input logic [N_PADS-1:0] cur,
    input logic [N_PADS-1:0] pol
  );
    return cur ^ pol;
  endfunction

  logic [N_PADS-1:0] prev_q;
  logic [N_PADS-1:0] edge_seen;
  logic [N_PADS-1:0] edge_armed;
  logic [N_PADS-1:0] set_mask;

  assign edge_seen  = directed_edge(pad_sync, prev_q, polar);
  assign edge_armed = arm & mode & CAP;
  assign set_mask   = edge_seen & edge_armed;
  assign level_hit  = active_level(pad_sync, polar) & arm & ~mode & CAP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      pending <= '0;
    end else begin
      prev_q  <= pad_sync;
      pending <= (pending & ~clr_mask) | set_mask;
    end
  end

  assign wake_req = (|level_hit) | (|pending);

  // R9: a pending bit only rises for a pad that was armed in edge mode.
  p_set_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & ~$past(pending) & ~$past(arm & mode)) == '0);

  // R8: a pending bit only falls after a clear write to it.
  p_clear_only_by_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pending) & ~pending & ~$past(clr_mask)) == '0);

  // R3: non-capable pads never hold a pending event.
  p_pending_capable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & ~CAP) == '0);

endmodule

// File: rtl/pad_wake_detector.sv
module pad_wake_detector
  import pwd_pkg::*;
#(
  parameter int unsigned N_PADS       = 8,
  parameter int unsigned MAX_WAKE_PAD = 5,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PADS-1:0] pad_in,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_waddr,
  input  logic [N_PADS-1:0] cfg_wdata,
  input  logic [1:0]        cfg_raddr,
  output logic [N_PADS-1:0] cfg_rdata,
  output logic              wake_req
);

  localparam logic [PWD_MAX_WIDTH-1:0] CAP_FULL = capable_mask(MAX_WAKE_PAD);
  localparam logic [N_PADS-1:0]        CAP      = CAP_FULL[N_PADS-1:0];

  logic [N_PADS-1:0] pad_sync;
  logic [N_PADS-1:0] arm_q, mode_q, polar_q;
  logic [N_PADS-1:0] clr_mask, pending, level_hit;

  pwd_sync #(.WIDTH(N_PADS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pad_in),
    .dout (pad_sync)
  );

  pwd_cfg_regs #(.N_PADS(N_PADS), .CAP(CAP)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .waddr   (cfg_waddr),
    .wdata   (cfg_wdata),
    .raddr   (cfg_raddr),
    .pending (pending),
    .arm_q   (arm_q),
    .mode_q  (mode_q),
    .polar_q (polar_q),
    .clr_mask(clr_mask),
    .rdata   (cfg_rdata)
  );

  pwd_detect #(.N_PADS(N_PADS), .CAP(CAP)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_sync (pad_sync),
    .arm      (arm_q),
    .mode     (mode_q),
    .polar    (polar_q),
    .clr_mask (clr_mask),
    .pending  (pending),
    .level_hit(level_hit),
    .wake_req (wake_req)
  );

  // R10: with nothing armed and nothing pending, no wake request.
  p_idle_no_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q == '0 && pending == '0) |-> !wake_req);

  // R8: a pending bit never changes from 1 to 0 without a write to address 3.
  p_pending_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_waddr == 2'd3) |=> (($past(pending) & ~pending) == '0));

endmodule

// File: tb/tb_pad_wake_detector.sv
module tb_pad_wake_detector;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam bit [N-1:0] CAPB = 8'h3F; // pads 0..5 wake-capable

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pad_in = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_waddr = '0;
  logic [N-1:0] cfg_wdata = '0;
  logic [1:0] cfg_raddr = '0;
  logic [N-1:0] cfg_rdata;
  logic wake_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_wake_detector dut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .wake_req(wake_req)
  );

  // Behavioural reference model
  bit [N-1:0] m_s1, m_s2, m_prev, m_arm, m_mode, m_pol, m_pend, m_set, m_next;
  bit m_wake;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0;
      m_arm = '0; m_mode = '0; m_pol = '0; m_pend = '0;
    end else begin
      m_set = '0;
      for (int i = 0; i < N; i++) begin
        if (m_arm[i] && m_mode[i] && CAPB[i]) begin
          if (!m_pol[i] && m_s2[i] && !m_prev[i]) m_set[i] = 1'b1;
          if (m_pol[i] && !m_s2[i] && m_prev[i]) m_set[i] = 1'b1;
        end
      end
      m_next = m_pend;
      if (cfg_we && cfg_waddr == 2'd3) m_next = m_next & ~cfg_wdata;
      m_next = m_next | m_set;
      if (cfg_we && cfg_waddr == 2'd0) m_arm  = cfg_wdata & CAPB;
      if (cfg_we && cfg_waddr == 2'd1) m_mode = cfg_wdata & CAPB;
      if (cfg_we && cfg_waddr == 2'd2) m_pol  = cfg_wdata & CAPB;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
      m_pend = m_next;
    end
    m_wake = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (m_pend[i]) m_wake = 1'b1;
      if (m_arm[i] && !m_mode[i] && CAPB[i] && (m_s2[i] != m_pol[i])) m_wake = 1'b1;
    end
  end

  // Per-cycle comparison against the model (R10 and timing of R4..R7)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (wake_req !== m_wake) begin
        errors++;
        $display("FAIL R10 per-cycle wake_req actual=%0b expected=%0b at %0t", wake_req, m_wake, $time);
      end
    end
  end

  task automatic chk_wake(input bit exp, input string req);
    checks++;
    if (wake_req !== exp) begin
      errors++;
      $display("FAIL %s wake_req actual=%0b expected=%0b", req, wake_req, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [N-1:0] exp, input string req);
    cfg_raddr = a;
    #1;
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read addr %0d actual=%h expected=%h", req, a, cfg_rdata, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(2'd0, '0); wr(2'd1, '0); wr(2'd2, '0);
    pad_in = '0;
    cyc(4);
    wr(2'd3, '1);
    cyc(1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1: reset state
    chk_wake(1'b0, "R1");
    for (int a = 0; a < 4; a++) rd(a[1:0], '0, "R1");

    // R2 and R3: write/read, non-capable bits dropped
    wr(2'd0, 8'hFF); rd(2'd0, 8'h3F, "R2");
    wr(2'd1, 8'hC5); rd(2'd1, 8'h05, "R3");
    wr(2'd2, 8'h0A); rd(2'd2, 8'h0A, "R2");
    rd(2'd3, 8'h00, "R2");
    quiesce();

    // R4: level high, two-edge latency, not latched
    wr(2'd0, 8'h01);
    pad_in[0] = 1'b1;
    cyc(1); chk_wake(1'b0, "R4");
    cyc(1); chk_wake(1'b1, "R4");
    cyc(3); chk_wake(1'b1, "R4");
    pad_in[0] = 1'b0;
    cyc(2); chk_wake(1'b0, "R4");
    rd(2'd3, 8'h00, "R4");

    // R5: level low with polarity set
    wr(2'd2, 8'h01);
    cyc(1); chk_wake(1'b1, "R5");
    pad_in[0] = 1'b1;
    cyc(2); chk_wake(1'b0, "R5");
    quiesce();

    // R6: rising edge latched
    wr(2'd1, 8'h02); wr(2'd0, 8'h02);
    cyc(2);
    pad_in[1] = 1'b1;
    cyc(2); chk_wake(1'b0, "R6");
    cyc(1); chk_wake(1'b1, "R6");
    rd(2'd3, 8'h02, "R6");
    pad_in[1] = 1'b0;
    cyc(4); chk_wake(1'b1, "R6");
    // R8: writing zero does not clear, writing one does
    wr(2'd3, 8'h00); rd(2'd3, 8'h02, "R8");
    wr(2'd3, 8'h02); rd(2'd3, 8'h00, "R8");
    chk_wake(1'b0, "R8");
    quiesce();

    // R7: falling edge with polarity set, rising ignored
    wr(2'd1, 8'h04); wr(2'd2, 8'h04); wr(2'd0, 8'h04);
    pad_in[2] = 1'b1;
    cyc(4); rd(2'd3, 8'h00, "R7"); chk_wake(1'b0, "R7");
    pad_in[2] = 1'b0;
    cyc(3); rd(2'd3, 8'h04, "R7"); chk_wake(1'b1, "R7");
    quiesce();

    // R8: edge arriving in the same cycle as its clear keeps the bit
    wr(2'd1, 8'h08); wr(2'd0, 8'h08);
    pad_in[3] = 1'b1;
    cyc(2);
    wr(2'd3, 8'h08);
    rd(2'd3, 8'h08, "R8");
    quiesce();

    // R9: disarmed pad toggles do nothing
    wr(2'd1, 8'h10);
    pad_in[4] = 1'b1; cyc(4); pad_in[4] = 1'b0; cyc(4);
    rd(2'd3, 8'h00, "R9"); chk_wake(1'b0, "R9");
    quiesce();

    // R3: non-capable pads never wake
    wr(2'd1, 8'hC0); wr(2'd0, 8'hC0);
    pad_in[7] = 1'b1; pad_in[6] = 1'b1; cyc(4);
    chk_wake(1'b0, "R3");
    pad_in[7] = 1'b0; cyc(4);
    rd(2'd3, 8'h00, "R3"); chk_wake(1'b0, "R3");
    quiesce();

    // R10: two sources, clearing one keeps request high
    wr(2'd1, 8'h20); wr(2'd0, 8'h21);
    pad_in[5] = 1'b1; pad_in[0] = 1'b1;
    cyc(4);
    chk_wake(1'b1, "R10");
    pad_in[0] = 1'b0; cyc(3);
    chk_wake(1'b1, "R10");
    wr(2'd3, 8'h20);
    chk_wake(1'b0, "R10");
    quiesce();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    done = 1'b1;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule